// File: doc/BRIEF.md
# Active Rail Gating Controller

This block handles the rail changes that must happen fast while the platform is awake, next to a slower main power sequencer. It takes the active-low S3 sleep signal, and also a backup request from the sequencer. When either trigger fires, it raises seven override lines to switch off the active-state power-ok and rail-enable lines. It raises them in a fixed order, one per clock. The last line, the IO rail enable, waits for a minimum spacing after the controller power-ok override. When the burst ends, the block sends a one-cycle done pulse. The overrides then stay set until the sleep signal returns high.

While the sleep signal is high and gating is enabled, the block also follows the processor's active-low deep-idle gate input. It drives the enable for the auxiliary S0 load-switch rails from that input. The two asynchronous inputs, sleep and idle gate, pass through a synchronizer of `SYNC_STAGES` flops. The sequencer inputs and the configuration bit are already on the block clock.

Top module: `active_rail_gate`

## Requirements
- R1: In reset, and on the first clock after reset, `off_req`, `s0_gate_on` and `teardown_done` are all zero.
- R2: A high-to-low change of `sleep_n` starts a teardown only if `plat_on` is high on the edge where the synchronized fall is seen. With two sync stages, `off_req[0]` sets on the third rising edge after the input changes. If `plat_on` is low, no override bit sets.
- R3: The overrides set in this fixed bit order, one bit per clock, and each set bit stays set: bit 0 auxiliary S0 rails, bit 1 sustain power-good, bit 2 controller power-ok, bit 3 system power-ok, bit 4 core regulator enable, bit 5 S0 rails enable, bit 6 IO rail enable.
- R4: `off_req[6]` sets exactly `MIN_GAP_CYC` clocks after `off_req[2]`, or 4 clocks after it if `MIN_GAP_CYC` is below 4.
- R5: `off_req[6]` sets no later than `DEADLINE_CYC` clocks after the teardown starts. With the defaults it sets 25 clocks after the sleep input falls.
- R6: `teardown_done` is high for exactly one clock, on the clock after `off_req[6]` sets.
- R7: While a teardown runs or its overrides are held, new sleep falls and new `seq_suspend` rises are ignored.
- R8: After a teardown the overrides stay at 7'h7F until the synchronized `sleep_n` rises. They then clear to zero on the third rising edge after the input rises.
- R9: A rising edge of `seq_suspend` starts a teardown whatever `plat_on` and `sleep_n` are. `off_req[0]` sets on the same clock edge that first samples `seq_suspend` high.
- R10: When `gate_en` is high and the synchronized `sleep_n` is high, `s0_gate_on` takes the level of `idle_gate_n`, three rising edges after that input changes.
- R11: When the synchronized `sleep_n` is low, or `gate_en` is low, `s0_gate_on` holds its value whatever `idle_gate_n` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_n | input | 1 | Asynchronous S3 sleep signal, low means sleep requested |
| idle_gate_n | input | 1 | Asynchronous deep-idle gate, low means rails may be gated |
| gate_en | input | 1 | Configuration bit that enables idle gating |
| plat_on | input | 1 | Platform is fully on, from the main sequencer |
| seq_suspend | input | 1 | Sequencer is in its active-to-suspend step (backup trigger) |
| off_req | output | 7 | Force-off overrides, bit order as in R3 |
| s0_gate_on | output | 1 | Auxiliary S0 rail enable from idle gating |
| teardown_done | output | 1 | One-cycle completion pulse to the sequencer |

## Verification
The asynchronous inputs reach the logic after two sync flops and one state flop. So a sleep fall shows on `off_req[0]` at the third edge, and an idle-gate change shows on `s0_gate_on` at the third edge. A `seq_suspend` rise shows at the first edge. The IO override follows `MIN_GAP_CYC` edges after bit 2, and the done pulse comes one edge after that. The bench model replays every input through a per-edge history queue. The model and the design are compared at each falling clock edge, so every one of these delays is checked at the exact cycle. Directed checks also measure the gap, the end-to-end latency and the number of done cycles from edge stamps taken by a port monitor.

// File: rtl/argate_pkg.sv
// Shared types and constants for the active rail gating controller.
package argate_pkg;

    // Number of override lines driven by the teardown burst
    localparam int N_LINES = 7;

    // Bit positions of the override vector (order is behaviour)
    localparam int LN_AUX  = 0;
    localparam int LN_SUSPG = 1;
    localparam int LN_CTLOK = 2;
    localparam int LN_SYSOK = 3;
    localparam int LN_CORE = 4;
    localparam int LN_S0   = 5;
    localparam int LN_IO   = 6;

    // Teardown sequencer states
    typedef enum logic [1:0] {
        TD_IDLE = 2'd0,
        TD_RUN  = 2'd1,
        TD_FIN  = 2'd2,
        TD_HOLD = 2'd3
    } td_state_e;

endpackage

// File: rtl/argate_sync.sv
// Multi-flop synchronizer with edge detection on the synchronized level.
// Assumes STAGES >= 2; all flops reset to zero (a low sleep level after
// reset looks like "already asleep" so no spurious fall is produced).
module argate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    // Shift the asynchronous input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], async_in};
    end

    // Remember the last synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sh_q[STAGES-1];
    end

    assign level = sh_q[STAGES-1];
    assign rise  = sh_q[STAGES-1] & ~prev_q;
    assign fall  = ~sh_q[STAGES-1] & prev_q;

endmodule

// File: rtl/argate_follow.sv
// Idle-gate follower: while gating is enabled and the platform is awake,
// registers the synchronized idle-gate level onto the S0 rail enable;
// otherwise the enable holds. Inputs are already synchronous.
module argate_follow (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en,
    input  logic awake,
    input  logic idle_lvl,
    output logic gate_on
);
    logic gate_q;
    logic active;

    assign active = gate_en & awake;

    // Track the idle-gate level only while gating is active
    always_ff @(posedge clk) begin
        if (!rst_n)      gate_q <= 1'b0;
        else if (active) gate_q <= idle_lvl;
    end

    assign gate_on = gate_q;

    // R11
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable(gate_q));

endmodule

// File: rtl/argate_teardown.sv
// Teardown burst sequencer: on start it sets override bit 0, then one bit
// per clock up to bit 5, then the IO bit once IO_AT clocks have passed
// since start (which keeps MIN_GAP_CYC clocks after bit 2). A done pulse
// follows; the overrides hold until clear_req. Starts are only accepted
// when idle, so repeated triggers are ignored.
module argate_teardown
    import argate_pkg::*;
#(
    parameter int MIN_GAP_CYC  = 20,
    parameter int DEADLINE_CYC = 10000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic               clear_req,
    output logic [N_LINES-1:0] off_o,
    output logic               done_o
);
    localparam int IO_AT = (MIN_GAP_CYC + LN_CTLOK > LN_S0 + 1) ? (MIN_GAP_CYC + LN_CTLOK) : (LN_S0 + 1);
    localparam int CNT_W = $clog2(IO_AT + 1);
    localparam int LAT_W = $clog2(DEADLINE_CYC + 2);
    localparam int GAP_W = $clog2(MIN_GAP_CYC + 2);

    td_state_e          st_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [N_LINES-1:0] off_q;
    logic [N_LINES-1:0] set_mask;
    logic               done_q;

    // Bit 0 sets on the accepted start
    assign set_mask[LN_AUX] = (st_q == TD_IDLE) & start_req;

    // Remaining bits each set at their own step count
    for (genvar i = 1; i < N_LINES; i++) begin : g_step
        localparam int AT = (i == LN_IO) ? IO_AT : i;
        assign set_mask[i] = (st_q == TD_RUN) && (cnt_q + 1'b1 == CNT_W'(AT));
    end

    // Sequencer state and step counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TD_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                TD_IDLE: if (start_req) begin
                    st_q  <= TD_RUN;
                    cnt_q <= '0;
                end
                TD_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q + 1'b1 == CNT_W'(IO_AT)) st_q <= TD_FIN;
                end
                TD_FIN:  st_q <= TD_HOLD;
                TD_HOLD: if (clear_req) st_q <= TD_IDLE;
                default: st_q <= TD_IDLE;
            endcase
        end
    end

    // Override bits accumulate during the burst and clear on release
    always_ff @(posedge clk) begin
        if (!rst_n)                           off_q <= '0;
        else if (st_q == TD_HOLD && clear_req) off_q <= '0;
        else                                  off_q <= off_q | set_mask;
    end

    // One-cycle completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (st_q == TD_FIN);
    end

    assign off_o  = off_q;
    assign done_o = done_q;

    // ---------------- checking logic ----------------
    logic [GAP_W-1:0] ctl_age_q;
    logic [LAT_W-1:0] lat_q;

    // Age of the controller power-ok override, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !off_q[LN_CTLOK])        ctl_age_q <= '0;
        else if (ctl_age_q != GAP_W'(MIN_GAP_CYC)) ctl_age_q <= ctl_age_q + 1'b1;
    end

    // Cycles since the burst began, saturating past the deadline
    always_ff @(posedge clk) begin
        if (!rst_n || off_q == '0)             lat_q <= '0;
        else if (lat_q != LAT_W'(DEADLINE_CYC + 1)) lat_q <= lat_q + 1'b1;
    end

    for (genvar j = 1; j < N_LINES; j++) begin : g_order_chk
        // R3
        order_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(off_q[j]) |-> off_q[j-1]);
    end

    // R4
    io_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(off_q[LN_IO]) |-> (ctl_age_q == GAP_W'(MIN_GAP_CYC)) || (MIN_GAP_CYC < 4));

    // R5
    io_deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(off_q[LN_IO]) |-> (lat_q <= LAT_W'(DEADLINE_CYC)));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R6
    done_after_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(off_q[LN_IO]) && off_q == '1);

endmodule

// File: rtl/active_rail_gate.sv
// Top of the active rail gating controller. Synchronizes the sleep and
// idle-gate inputs, forms the teardown trigger (qualified sleep fall or a
// sequencer suspend-entry rise), and hosts the burst sequencer and the
// idle-gate follower. plat_on, seq_suspend and gate_en are synchronous.
module active_rail_gate
    import argate_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int MIN_GAP_CYC  = 20,
    parameter int DEADLINE_CYC = 10000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_n,
    input  logic               idle_gate_n,
    input  logic               gate_en,
    input  logic               plat_on,
    input  logic               seq_suspend,
    output logic [N_LINES-1:0] off_req,
    output logic               s0_gate_on,
    output logic               teardown_done
);
    logic sleep_lvl, sleep_rise, sleep_fall;
    logic idle_lvl, idle_rise_nc, idle_fall_nc;
    logic susp_q;
    logic start_req;

    argate_sync #(.STAGES(SYNC_STAGES)) u_sync_sleep (
        .clk(clk), .rst_n(rst_n), .async_in(sleep_n),
        .level(sleep_lvl), .rise(sleep_rise), .fall(sleep_fall)
    );

    argate_sync #(.STAGES(SYNC_STAGES)) u_sync_idle (
        .clk(clk), .rst_n(rst_n), .async_in(idle_gate_n),
        .level(idle_lvl), .rise(idle_rise_nc), .fall(idle_fall_nc)
    );

    // Previous suspend-entry level for rise detection
    always_ff @(posedge clk) begin
        if (!rst_n) susp_q <= 1'b0;
        else        susp_q <= seq_suspend;
    end

    assign start_req = (sleep_fall & plat_on) | (seq_suspend & ~susp_q);

    argate_teardown #(
        .MIN_GAP_CYC(MIN_GAP_CYC),
        .DEADLINE_CYC(DEADLINE_CYC)
    ) u_td (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .clear_req(sleep_rise),
        .off_o(off_req), .done_o(teardown_done)
    );

    argate_follow u_follow (
        .clk(clk), .rst_n(rst_n), .gate_en(gate_en),
        .awake(sleep_lvl), .idle_lvl(idle_lvl), .gate_on(s0_gate_on)
    );

    // R2
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off_req == '0 && !plat_on && !(seq_suspend && !susp_q)) |=> (off_req == '0));

endmodule

// File: tb/sim_active_rail_gate.sv
module sim_active_rail_gate;
    localparam int GAP   = 20;
    localparam int DL    = 10000;
    localparam int IO_AT = GAP + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_n = 1'b0, idle_gate_n = 1'b0, gate_en = 1'b0;
    logic plat_on = 1'b0, seq_suspend = 1'b0;
    logic [6:0] off_req;
    logic s0_gate_on, teardown_done;

    int n_chk = 0, n_bad = 0;
    int cyc_ctr = 0;

    active_rail_gate #(.SYNC_STAGES(2), .MIN_GAP_CYC(GAP), .DEADLINE_CYC(DL)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .idle_gate_n(idle_gate_n),
        .gate_en(gate_en), .plat_on(plat_on), .seq_suspend(seq_suspend),
        .off_req(off_req), .s0_gate_on(s0_gate_on), .teardown_done(teardown_done)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc_ctr);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit sq[$];      // sleep input history, newest first
    bit iq[$];      // idle-gate input history, newest first
    bit m_susp_last;
    int m_phase;    // 0 idle, 1 running, 2 finishing, 3 holding
    int m_cnt;
    logic [6:0] m_off;
    logic m_gate, m_done;
    bit started = 0;

    always @(posedge clk) begin
        cyc_ctr++;
        started = 1;
        if (!rst_n) begin
            sq = '{0, 0, 0}; iq = '{0, 0, 0};
            m_susp_last = 0; m_phase = 0; m_cnt = 0;
            m_off = '0; m_gate = 0; m_done = 0;
        end else begin
            bit s_fall, s_rise, go;
            s_fall = !sq[1] && sq[2];
            s_rise = sq[1] && !sq[2];
            go = (s_fall && plat_on) || (seq_suspend && !m_susp_last);
            if (gate_en && sq[1]) m_gate = iq[1];
            m_done = 0;
            case (m_phase)
                0: if (go) begin m_phase = 1; m_cnt = 0; m_off[0] = 1; end
                1: begin
                    m_cnt++;
                    if (m_cnt <= 5) m_off[m_cnt] = 1;
                    if (m_cnt == IO_AT) begin m_off[6] = 1; m_phase = 2; end
                end
                2: begin m_done = 1; m_phase = 3; end
                default: if (s_rise) begin m_off = '0; m_phase = 0; end
            endcase
            m_susp_last = seq_suspend;
            sq.push_front(sleep_n); void'(sq.pop_back());
            iq.push_front(idle_gate_n); void'(iq.pop_back());
        end
    end

    // Every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk("R3 off_req vs model", int'(off_req), int'(m_off));
            chk("R6 teardown_done vs model", int'(teardown_done), int'(m_done));
            chk("R10 s0_gate_on vs model", int'(s0_gate_on), int'(m_gate));
        end
    end

    // Port monitor: edge stamps of key override bits and done
    logic [6:0] mon_prev = '0;
    int ctl_t = 0, io_t = 0, done_t = 0, done_cnt = 0;
    always @(negedge clk) begin
        if (off_req[2] && !mon_prev[2]) ctl_t = cyc_ctr;
        if (off_req[6] && !mon_prev[6]) io_t = cyc_ctr;
        if (teardown_done) begin done_cnt++; done_t = cyc_ctr; end
        mon_prev = off_req;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int c0;
        cyc(4);
        // R1
        chk("R1 off_req reset", int'(off_req), 0);
        chk("R1 s0_gate_on reset", int'(s0_gate_on), 0);
        chk("R1 done reset", int'(teardown_done), 0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 off_req after reset", int'(off_req), 0);

        // R10: follow with three-edge latency
        sleep_n = 1; gate_en = 1; idle_gate_n = 1;
        cyc(3); chk("R10 gate follows high", int'(s0_gate_on), 1);
        idle_gate_n = 0;
        cyc(2); chk("R10 not yet at edge 2", int'(s0_gate_on), 1);
        cyc(1); chk("R10 follows low at edge 3", int'(s0_gate_on), 0);

        // R11: gating disabled holds
        gate_en = 0; idle_gate_n = 1;
        cyc(5); chk("R11 hold with gate_en low", int'(s0_gate_on), 0);
        gate_en = 1;
        cyc(2); chk("R10 resumes", int'(s0_gate_on), 1);

        // R2: fall with platform off starts nothing
        sleep_n = 0;
        cyc(8); chk("R2 no start with plat_on low", int'(off_req), 0);
        // R11: sleep low, gate input ignored
        idle_gate_n = 0;
        cyc(5); chk("R11 hold while asleep", int'(s0_gate_on), 1);

        // Qualified fall starts the burst
        sleep_n = 1; cyc(4);
        plat_on = 1;
        c0 = cyc_ctr;
        sleep_n = 0;
        cyc(2); chk("R2 no override before edge 3", int'(off_req), 0);
        cyc(1); chk("R2 bit0 at edge 3", int'(off_req), 7'h01);
        cyc(1); chk("R3 bit1 next", int'(off_req), 7'h03);
        cyc(1); chk("R3 bit2 next", int'(off_req), 7'h07);
        // R7: bounce the sleep input during the run
        sleep_n = 1; cyc(3); sleep_n = 0;
        cyc(30);
        chk("R8 held all set", int'(off_req), 7'h7F);
        chk("R4 io gap", io_t - ctl_t, GAP);
        chk("R5 io latency from input", io_t - c0, IO_AT + 3);
        chk("R5 within deadline", int'(io_t - c0 <= DL), 1);
        chk("R6 done one edge after io", done_t - io_t, 1);
        // R7: suspend rise while held is ignored
        seq_suspend = 1; cyc(2); seq_suspend = 0; cyc(3);
        chk("R7 held ignores trigger", int'(off_req), 7'h7F);
        chk("R7 no second done", done_cnt, 1);

        // R8: release on sleep rise, third edge
        sleep_n = 1;
        cyc(2); chk("R8 still held at edge 2", int'(off_req), 7'h7F);
        cyc(1); chk("R8 cleared at edge 3", int'(off_req), 0);

        // R9: backup trigger regardless of plat_on
        plat_on = 0; cyc(2);
        seq_suspend = 1;
        cyc(1); chk("R9 bit0 on first edge", int'(off_req), 7'h01);
        seq_suspend = 0;
        cyc(30);
        chk("R9 full burst", int'(off_req), 7'h7F);
        chk("R6 done count", done_cnt, 2);
        sleep_n = 0; cyc(4); sleep_n = 1; cyc(4);
        chk("R8 cleared after backup run", int'(off_req), 0);

        cyc(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule